// File: doc/BRIEF.md
# Mixed-Width Register Access Bridge

The bridge sits between a CPU port and a peripheral register file. The CPU port issues byte, halfword or word accesses in big-endian order. Each register in the file has its own native width of one, two or four bytes. A width table holds one entry for each 4-byte slot of the offset space. For every access the bridge turns the request into a series of native-width register transactions. It issues exactly one transaction per clock cycle.

Some accesses are wider than the register they hit. These are cut into halves and then into bytes, and the table is consulted again at every sub-offset. Some accesses are narrower than the register. A narrow read fetches the whole register and extracts the addressed lane. A narrow write becomes a read-modify-write: the bridge reads the register, replaces the addressed lane and writes the register back. Offsets outside the table and slots without a register end the access with an error flag. No transaction is issued for them.

A one-cycle done strobe closes each access. On a read it carries the assembled data, right-justified. The register file answers reads combinationally, in the same cycle as the request.

Top module: `regwidth_bridge`

## Requirements
- R1: The native width of an offset comes from the table entry selected by offset bits 8:2. Entry codes are 0 = no register, 1 = byte, 2 = halfword, 3 = word. The CPU size codes are 0 = byte, 1 = halfword, 2 = word. The same width code appears on `reg_size` for every transaction, and each transaction address is aligned to that width. The default table repeats the pattern byte, halfword, word, none over consecutive slots.
- R2: Any offset at or above 0x200 ends the access with `cpu_err` high, zero data and no register transaction.
- R3: An access to a slot whose code is 0 ends with `cpu_err` high and zero data, with no register transaction. `cpu_done` is high in the second cycle after the request is accepted.
- R4: When the access width equals the native width, exactly one transaction is issued. It is a read or a write, according to the access.
- R5: A byte read from a halfword register reads the aligned halfword. An even offset returns its upper byte and an odd offset returns its lower byte.
- R6: A halfword read from a word register reads the aligned word. Offset bits 1:0 equal to 0 return the upper half; any other value returns the lower half.
- R7: A halfword access to a byte register becomes two byte transactions. The first is at the offset and carries data bits 15:8. The second is at offset+1 and carries data bits 7:0.
- R8: A word access to a narrower register becomes two halfword accesses. The one at the offset carries bits 31:16 and the one at offset+2 carries bits 15:0. Each halfword is split again into bytes if its register is a byte register.
- R9: A byte write to a halfword register is a read of the halfword followed by a write of it. Only the addressed byte changes; an even offset selects the upper byte.
- R10: A halfword write to a word register is a read of the word followed by a write of it. Only the addressed half changes.
- R11: A byte write to a word register is one read followed by one write of the word. It replaces the byte lane given by offset bits 1:0, with lane 0 as the most significant byte.
- R12: `cpu_done` is a one-cycle pulse. With it, `cpu_rdata` carries the read value right-justified. For writes and errors, `cpu_rdata` is zero.
- R13: Transactions occur in consecutive cycles, starting in the cycle after the request is accepted. `cpu_done` rises in the cycle after the last transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, accepted when the bridge is idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Access size code (0 byte, 1 halfword, 2 word) |
| cpu_addr | input | AW | Byte offset |
| cpu_wdata | input | 32 | Write data, right-justified |
| cpu_done | output | 1 | Access complete strobe |
| cpu_err | output | 1 | Access hit no register, valid with done |
| cpu_rdata | output | 32 | Read data, right-justified, valid with done |
| reg_req | output | 1 | Register transaction in this cycle |
| reg_we | output | 1 | Transaction is a write |
| reg_size | output | 2 | Native width code of the transaction |
| reg_addr | output | AW | Width-aligned register offset |
| reg_wdata | output | 32 | Native write value, right-justified |
| reg_rdata | input | 32 | Native read value, same cycle as the request |

## Verification
Take a successful access that needs T register transactions. Its transactions appear in the T cycles after acceptance, and its done strobe comes T+1 cycles after acceptance. An access that ends in error shows its done strobe two cycles after acceptance, with no transaction. The driver stamps every expected item with the cycle counter at the moment it raises the request. The monitor samples on falling edges, counts the transactions and writes it sees, and compares the elapsed cycles at the done strobe with the latency the driver computed from the width table. Read data is predicted from a byte-level shadow of the register contents. Read-back accesses after each merged write show that the neighbouring lanes kept their values.

// File: rtl/rwb_pkg.sv
package rwb_pkg;

    localparam int DW = 32;

    typedef enum logic [1:0] {
        NW_NONE = 2'd0,
        NW_B    = 2'd1,
        NW_H    = 2'd2,
        NW_W    = 2'd3
    } native_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_WBACK = 2'd2
    } state_e;

    // CPU size code to byte count
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [2:0] native_bytes(input native_e w);
        case (w)
            NW_B:    return 3'd1;
            NW_H:    return 3'd2;
            NW_W:    return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    // Bytes handled by the next step: a word splits into halves, a half into bytes
    function automatic logic [2:0] chunk_len(input logic [2:0] rem, input logic [2:0] nb);
        logic [2:0] lim;
        if (rem == 3'd4 && nb == 3'd4) return 3'd4;
        lim = (rem == 3'd4) ? 3'd2 : ((rem == 3'd3) ? 3'd1 : rem);
        return (nb >= lim) ? lim : nb;
    endfunction

    function automatic logic [DW-1:0] byte_mask(input logic [2:0] n);
        case (n)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            3'd4:    return 32'hFFFF_FFFF;
            default: return 32'h0000_0000;
        endcase
    endfunction

    // Default striped table: byte, halfword, word, empty
    function automatic native_e stripe_code(input logic [1:0] s);
        case (s)
            2'd0:    return NW_B;
            2'd1:    return NW_H;
            2'd2:    return NW_W;
            default: return NW_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rwb_lookup.sv
module rwb_lookup
    import rwb_pkg::*;
#(
    parameter int              SLOTS      = 128,
    parameter int              AW         = 10,
    parameter bit              USE_STRIPE = 1'b1,
    parameter logic [2*SLOTS-1:0] WMAP    = '0
) (
    input  logic [AW-1:0] addr,
    output native_e       width,
    output logic          bad
);
    localparam int IW    = $clog2(SLOTS);
    localparam int LIMIT = SLOTS * 4;

    native_e         tab [SLOTS];
    logic            in_range;
    logic [IW-1:0]   slot;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        if (USE_STRIPE) begin : g_stripe
            assign tab[s] = stripe_code(2'(s));
        end else begin : g_map
            assign tab[s] = native_e'(WMAP[2*s +: 2]);
        end
    end

    assign in_range = ({{(32-AW){1'b0}}, addr} < 32'(LIMIT));
    assign slot     = addr[IW+1:2];
    assign width    = in_range ? tab[slot] : NW_NONE;
    assign bad      = (width == NW_NONE);

endmodule

// File: rtl/rwb_lane.sv
module rwb_lane
    import rwb_pkg::*;
(
    input  logic [2:0]    nb,
    input  logic [2:0]    clen,
    input  logic [1:0]    lo,
    input  logic [DW-1:0] nat_val,
    input  logic [DW-1:0] wr_piece,
    output logic [DW-1:0] rd_piece,
    output logic [DW-1:0] nat_new
);
    logic [2:0]    idx;
    logic [1:0]    pos;
    logic [DW-1:0] m;
    logic [DW-1:0] sm;

    always_comb begin
        // idx: lane number counted from the most significant byte
        idx = 3'd0;
        if (nb == 3'd2 && clen == 3'd1)      idx = {2'b00, lo[0]};
        else if (nb == 3'd4 && clen == 3'd1) idx = {1'b0, lo};
        else if (nb == 3'd4 && clen == 3'd2) idx = (lo == 2'd0) ? 3'd0 : 3'd2;
        pos      = 2'(nb - idx - clen);
        m        = byte_mask(clen);
        sm       = m << {pos, 3'b000};
        rd_piece = (nat_val >> {pos, 3'b000}) & m;
        nat_new  = (nat_val & ~sm) | ((wr_piece & m) << {pos, 3'b000});
    end

endmodule

// File: rtl/regwidth_bridge.sv
module regwidth_bridge
    import rwb_pkg::*;
#(
    parameter int                 SLOTS      = 128,
    parameter int                 AW         = 10,
    parameter bit                 USE_STRIPE = 1'b1,
    parameter logic [2*SLOTS-1:0] WMAP       = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [1:0]    cpu_size,
    input  logic [AW-1:0] cpu_addr,
    input  logic [31:0]   cpu_wdata,
    output logic          cpu_done,
    output logic          cpu_err,
    output logic [31:0]   cpu_rdata,
    output logic          reg_req,
    output logic          reg_we,
    output logic [1:0]    reg_size,
    output logic [AW-1:0] reg_addr,
    output logic [31:0]   reg_wdata,
    input  logic [31:0]   reg_rdata
);
    state_e        state;
    logic          we_q;
    logic [AW-1:0] addr_q;
    logic [2:0]    rem_q;
    logic [DW-1:0] wdat_q;
    logic [DW-1:0] acc_q;
    logic [DW-1:0] hold_q;
    logic [AW-1:0] hold_addr;
    native_e       hold_w;
    logic          done_q;
    logic          err_q;
    logic [DW-1:0] rdata_q;

    native_e       nw;
    logic          bad;
    logic [2:0]    nb;
    logic [2:0]    clen;
    logic [2:0]    rem_n;
    logic [DW-1:0] piece_w;
    logic [DW-1:0] piece_r;
    logic [DW-1:0] merged;
    logic [DW-1:0] acc_n;
    logic [AW-1:0] base;

    rwb_lookup #(
        .SLOTS(SLOTS), .AW(AW), .USE_STRIPE(USE_STRIPE), .WMAP(WMAP)
    ) u_look (
        .addr(addr_q), .width(nw), .bad(bad)
    );

    assign nb      = native_bytes(nw);
    assign clen    = chunk_len(rem_q, nb);
    assign rem_n   = rem_q - clen;
    assign piece_w = wdat_q >> {rem_n, 3'b000};
    assign base    = addr_q & ~{{(AW-3){1'b0}}, nb - 3'd1};
    assign acc_n   = (acc_q << {clen, 3'b000}) | piece_r;

    rwb_lane u_lane (
        .nb(nb), .clen(clen), .lo(addr_q[1:0]),
        .nat_val(reg_rdata), .wr_piece(piece_w),
        .rd_piece(piece_r), .nat_new(merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            we_q      <= 1'b0;
            addr_q    <= '0;
            rem_q     <= '0;
            wdat_q    <= '0;
            acc_q     <= '0;
            hold_q    <= '0;
            hold_addr <= '0;
            hold_w    <= NW_NONE;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            rdata_q   <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cpu_req) begin
                        addr_q <= cpu_addr;
                        we_q   <= cpu_we;
                        rem_q  <= size_bytes(cpu_size);
                        wdat_q <= cpu_wdata;
                        acc_q  <= '0;
                        state  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (bad) begin
                        done_q  <= 1'b1;
                        err_q   <= 1'b1;
                        rdata_q <= '0;
                        state   <= ST_IDLE;
                    end else begin
                        rem_q  <= rem_n;
                        addr_q <= addr_q + AW'(clen);
                        acc_q  <= acc_n;
                        if (we_q && clen != nb) begin
                            hold_q    <= merged;
                            hold_addr <= base;
                            hold_w    <= nw;
                            state     <= ST_WBACK;
                        end else if (rem_n == 3'd0) begin
                            done_q  <= 1'b1;
                            rdata_q <= we_q ? '0 : acc_n;
                            state   <= ST_IDLE;
                        end
                    end
                end
                ST_WBACK: begin
                    if (rem_q == 3'd0) begin
                        done_q  <= 1'b1;
                        rdata_q <= '0;
                        state   <= ST_IDLE;
                    end else begin
                        state <= ST_RUN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        reg_req   = 1'b0;
        reg_we    = 1'b0;
        reg_size  = NW_NONE;
        reg_addr  = base;
        reg_wdata = merged;
        if (state == ST_RUN && !bad) begin
            reg_req  = 1'b1;
            reg_we   = we_q && (clen == nb);
            reg_size = nw;
        end else if (state == ST_WBACK) begin
            reg_req   = 1'b1;
            reg_we    = 1'b1;
            reg_size  = hold_w;
            reg_addr  = hold_addr;
            reg_wdata = hold_q;
        end
    end

    assign cpu_done  = done_q;
    assign cpu_err   = err_q;
    assign cpu_rdata = rdata_q;

endmodule

// File: rtl/rwb_props.sv
module rwb_props #(
    parameter int AW    = 10,
    parameter int SLOTS = 128
) (
    input logic          clk,
    input logic          rst,
    input logic          cpu_done,
    input logic          cpu_err,
    input logic [31:0]   cpu_rdata,
    input logic          reg_req,
    input logic [1:0]    reg_size,
    input logic [AW-1:0] reg_addr
);
    localparam int LIMIT = SLOTS * 4;

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

    p_err_with_done_r3: assert property (@(posedge clk) disable iff (rst)
        cpu_err |-> cpu_done);

    p_err_zero_data_r3: assert property (@(posedge clk) disable iff (rst)
        cpu_err |-> (cpu_rdata == 32'd0));

    p_txn_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        reg_req |-> ({{(32-AW){1'b0}}, reg_addr} < 32'(LIMIT)));

    p_txn_has_width_r1: assert property (@(posedge clk) disable iff (rst)
        reg_req |-> (reg_size != 2'd0));

    p_word_aligned_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_size == 2'd3) |-> (reg_addr[1:0] == 2'b00));

    p_half_aligned_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_size == 2'd2) |-> (reg_addr[0] == 1'b0));

endmodule

bind regwidth_bridge rwb_props #(.AW(AW), .SLOTS(SLOTS)) u_props (
    .clk(clk), .rst(rst), .cpu_done(cpu_done), .cpu_err(cpu_err),
    .cpu_rdata(cpu_rdata), .reg_req(reg_req), .reg_size(reg_size),
    .reg_addr(reg_addr)
);

// File: tb/sim_regwidth_bridge.sv
module sim_regwidth_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [9:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_done;
    logic        cpu_err;
    logic [31:0] cpu_rdata;
    logic        reg_req;
    logic        reg_we;
    logic [1:0]  reg_size;
    logic [9:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    regwidth_bridge u0 (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
        .reg_req(reg_req), .reg_we(reg_we), .reg_size(reg_size),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 37 + 11);
    endfunction

    // register file model: byte storage, native-width access
    logic [7:0] mem [0:511];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 512; i++) mem[i] <= pat(i);
        end else if (reg_req && reg_we) begin
            if (reg_size == 2'd1) mem[reg_addr] <= reg_wdata[7:0];
            else if (reg_size == 2'd2) begin
                mem[reg_addr]     <= reg_wdata[15:8];
                mem[reg_addr + 1] <= reg_wdata[7:0];
            end else if (reg_size == 2'd3) begin
                mem[reg_addr]     <= reg_wdata[31:24];
                mem[reg_addr + 1] <= reg_wdata[23:16];
                mem[reg_addr + 2] <= reg_wdata[15:8];
                mem[reg_addr + 3] <= reg_wdata[7:0];
            end
        end
    end

    always_comb begin
        int a;
        a = int'(reg_addr);
        reg_rdata = 32'd0;
        if (a + 3 < 512) begin
            if (reg_size == 2'd1) reg_rdata = {24'd0, mem[a]};
            else if (reg_size == 2'd2) reg_rdata = {16'd0, mem[a], mem[a+1]};
            else if (reg_size == 2'd3) reg_rdata = {mem[a], mem[a+1], mem[a+2], mem[a+3]};
        end
    end

    // shadow of the expected register contents
    logic [7:0] sh [0:511];

    typedef struct {
        logic [31:0] rd;
        logic        err;
        int          ntx;
        int          nwr;
        int          lat;
        logic [9:0]  first;
        int          start;
        string       tag;
    } exp_t;

    exp_t q[$];

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // native width in bytes from the default striped table (R1)
    function automatic int nat(input logic [9:0] a);
        if (a >= 10'h200) return 0;
        case (a[3:2])
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 4;
            default: return 0;
        endcase
    endfunction

    // driver: computes the expectation, pushes it, runs the access
    task automatic op(input logic we, input logic [1:0] sz, input logic [9:0] a,
                      input logic [31:0] wd, input string tag);
        exp_t e;
        int A, N;
        A = (sz == 2'd0) ? 1 : ((sz == 2'd1) ? 2 : 4);
        N = nat(a);
        e.tag = tag;
        e.start = cyc;
        e.rd = 32'd0;
        e.err = 1'b0;
        e.first = a;
        if (N == 0) begin
            e.err = 1'b1; e.ntx = 0; e.nwr = 0; e.lat = 2;
        end else begin
            if (A == N) begin
                e.ntx = 1; e.nwr = we ? 1 : 0;
            end else if (A < N) begin
                e.ntx = we ? 2 : 1; e.nwr = we ? 1 : 0;
                e.first = a & ~10'(N - 1);
            end else begin
                e.ntx = A / N; e.nwr = we ? A / N : 0;
            end
            e.lat = e.ntx + 1;
            if (we) begin
                for (int k = 0; k < A; k++) sh[int'(a) + k] = wd[8*(A-1-k) +: 8];
            end else begin
                for (int k = 0; k < A; k++) e.rd = (e.rd << 8) | {24'd0, sh[int'(a) + k]};
            end
        end
        q.push_back(e);
        cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        while (!cpu_done) @(negedge clk);
    endtask

    // monitor: counts transactions, pops and compares at each done
    int m_ntx = 0;
    int m_nwr = 0;
    logic [9:0] m_first = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (reg_req) begin
                if (m_ntx == 0) m_first = reg_addr;
                m_ntx++;
                if (reg_we) m_nwr++;
            end
            if (cpu_done) begin
                if (q.size() == 0) begin
                    check("R12", "unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(e.tag, "err", {31'd0, cpu_err}, {31'd0, e.err});
                    check(e.tag, "data", cpu_rdata, e.rd);
                    check(e.tag, "txn count", 32'(m_ntx), 32'(e.ntx));
                    check(e.tag, "write count", 32'(m_nwr), 32'(e.nwr));
                    check("R13", "latency", 32'(cyc - e.start), 32'(e.lat));
                    if (e.ntx > 0) check(e.tag, "first addr", {22'd0, m_first}, {22'd0, e.first});
                end
                m_ntx = 0;
                m_nwr = 0;
            end
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) sh[i] = pat(i);
        repeat (3) @(negedge clk);
        check("R12", "reset done", {31'd0, cpu_done}, 32'd0);
        check("R13", "reset txn", {31'd0, reg_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R12", "idle done", {31'd0, cpu_done}, 32'd0);

        op(1'b0, 2'd0, 10'h001, 32'h0, "R4");   // byte reg, byte read
        op(1'b0, 2'd1, 10'h004, 32'h0, "R4");   // halfword reg, halfword read
        op(1'b0, 2'd2, 10'h008, 32'h0, "R4");   // word reg, word read
        op(1'b0, 2'd0, 10'h004, 32'h0, "R5");   // even: upper byte
        op(1'b0, 2'd0, 10'h005, 32'h0, "R5");   // odd: lower byte
        op(1'b0, 2'd1, 10'h008, 32'h0, "R6");   // upper half
        op(1'b0, 2'd1, 10'h00A, 32'h0, "R6");   // lower half
        op(1'b0, 2'd1, 10'h002, 32'h0, "R7");
        op(1'b0, 2'd2, 10'h010, 32'h0, "R8");   // four byte reads
        op(1'b0, 2'd2, 10'h014, 32'h0, "R8");   // two halfword reads
        op(1'b1, 2'd0, 10'h015, 32'h0000_00A5, "R9");
        op(1'b0, 2'd1, 10'h014, 32'h0, "R9");
        op(1'b1, 2'd0, 10'h024, 32'h0000_003C, "R9");
        op(1'b0, 2'd1, 10'h024, 32'h0, "R9");
        op(1'b1, 2'd1, 10'h01A, 32'h0000_BEEF, "R10");
        op(1'b0, 2'd2, 10'h018, 32'h0, "R10");
        op(1'b1, 2'd1, 10'h028, 32'h0000_1234, "R10");
        op(1'b0, 2'd2, 10'h028, 32'h0, "R10");
        op(1'b1, 2'd0, 10'h039, 32'h0000_00C7, "R11");
        op(1'b0, 2'd2, 10'h038, 32'h0, "R11");
        op(1'b1, 2'd0, 10'h04B, 32'h0000_0019, "R11");
        op(1'b0, 2'd2, 10'h048, 32'h0, "R11");
        op(1'b1, 2'd1, 10'h022, 32'h0000_5A6B, "R7");
        op(1'b0, 2'd1, 10'h022, 32'h0, "R7");
        op(1'b1, 2'd2, 10'h030, 32'hDEAD_F00D, "R8");
        op(1'b0, 2'd2, 10'h030, 32'h0, "R8");
        op(1'b1, 2'd2, 10'h054, 32'hCAFE_0101, "R8");
        op(1'b0, 2'd2, 10'h054, 32'h0, "R8");
        op(1'b1, 2'd2, 10'h058, 32'h7654_3210, "R4");
        op(1'b0, 2'd2, 10'h058, 32'h0, "R4");
        op(1'b0, 2'd1, 10'h00C, 32'h0, "R3");
        op(1'b1, 2'd2, 10'h01C, 32'h1111_1111, "R3");
        op(1'b0, 2'd2, 10'h018, 32'h0, "R3");   // unchanged after refused write
        op(1'b0, 2'd0, 10'h200, 32'h0, "R2");
        op(1'b1, 2'd2, 10'h3FC, 32'h2222_2222, "R2");
        op(1'b0, 2'd2, 10'h1F8, 32'h0, "R1");   // last word slot in range

        repeat (3) @(negedge clk);
        check("R12", "pending items", 32'(q.size()), 32'd0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R13 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule